// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Encoded Invalidation

This block is a small fully associative translation cache for a 32-bit I/O virtual address space with 4 KiB pages. Every line holds a virtual page number (VA[31:12]), a 7-bit address-space tag, a physical frame number and three permission bits. A combinational lookup port takes an address-space tag and a page number and returns hit, frame and permissions in the same cycle. On a miss, an external table walker writes the translation through the fill port.

Invalidation is requested with a single 32-bit command word. Its two low bits choose what is removed. It can remove every line, every line in a 4 MiB region, or every line in a 16 KiB region of four pages. Each of these can be narrowed to one address space. Two configuration inputs shape the cache. One sets how many lines take part, counted from line 0. The other chooses between round-robin victim choice and first-free-line victim choice.

Top module: `iotlb_asid`

## Requirements
- R1: After a synchronous active-low reset every line is invalid and every lookup misses.
- R2: A lookup hits when a valid line inside the active region holds the same tag and page number. It then returns that line's frame and permission bits. On a miss the frame and permission outputs are zero.
- R3: Command bits [1:0] = 0 invalidates every line. If command bit 31 is set, it invalidates only lines whose tag equals command bits [30:24].
- R4: Command bits [1:0] = 2 invalidates lines whose VA[31:22] (page number bits [19:10]) equals command bits [19:10]. Bit 31 narrows it to one tag as in R3. With bit 31 clear, lines of all tags are removed.
- R5: Command bits [1:0] = 3 invalidates lines whose VA[31:14] (page number bits [19:2]) equals command bits [19:2]. Bit 31 narrows it to one tag as in R3.
- R6: Command bits [1:0] = 1 has no effect on the stored lines.
- R7: An invalidation takes effect in the cycle it is presented. A lookup in that cycle already misses on the removed lines. A fill in the same cycle is applied after the invalidation.
- R8: Only lines 0 to cfg_active_lines-1 can hit or be allocated. With a count of zero, every lookup misses and fills are dropped.
- R9: With cfg_rr_en = 1, a new translation goes to the line under a rotating pointer. The pointer advances by one after each allocation and wraps at the active count. A pointer at or beyond the count is treated as 0.
- R10: With cfg_rr_en = 0, a new translation goes to the lowest-numbered invalid active line, or to line 0 if none is free. The rotating pointer is held.
- R11: A fill whose tag and page number already sit in an active line overwrites that line in place and does not move the pointer. A copy outside the active region is invalidated, so no key is ever stored twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_active_lines | input | 4 | Number of lines in use, 0..8 |
| cfg_rr_en | input | 1 | 1 = rotating victim pointer, 0 = first free line |
| lk_asid | input | 7 | Lookup address-space tag |
| lk_vpn | input | 20 | Lookup virtual page number (VA[31:12]) |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 20 | Physical frame number on hit, else 0 |
| lk_perm | output | 3 | Permission bits on hit, else 0 |
| fill_valid | input | 1 | Write a translation this cycle |
| fill_asid | input | 7 | Fill address-space tag |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_pfn | input | 20 | Fill physical frame number |
| fill_perm | input | 3 | Fill permission bits |
| flush_valid | input | 1 | Invalidation command present this cycle |
| flush_cmd | input | 32 | Encoded invalidation command |

## Verification
The hardest situation to reach is the one where an invalidation, a fill and a lookup meet in the same cycle while the active region is smaller than a line that still holds a stale copy of the filled key. This exercises the ordering of R7 together with the duplicate removal of R11. A directed sequence builds that state deliberately. It fills lines with a large active count, shrinks the count, refills the same key and then grows the count again. A seeded random phase draws tags from a set of four and page numbers from a narrow pool spread over two regions, so that region and group invalidations hit real lines often. It mixes fills, invalidations, configuration changes and lookups in the same cycles.

// File: rtl/iotlb_pkg.sv
// Shared types for the translation cache.
// Assumes 4 KiB pages (page number = VA[31:12]) and a 32-bit command word.
package iotlb_pkg;
    localparam int ASID_W   = 7;
    localparam int VPN_W    = 20;
    localparam int PFN_W    = 20;
    localparam int PERM_W   = 3;
    localparam int PAGE_SH  = 12;
    // region boundaries expressed as page-number bit positions
    localparam int SECT_LSB = 22 - PAGE_SH;
    localparam int GRP_LSB  = 14 - PAGE_SH;

    typedef enum logic [1:0] {
        FL_ALL  = 2'b00,
        FL_NONE = 2'b01,
        FL_SECT = 2'b10,
        FL_GRP  = 2'b11
    } flush_mode_e;

    typedef struct packed {
        logic              vld;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic [PERM_W-1:0] perm;
    } tlb_line_t;

    typedef struct packed {
        logic              act;
        flush_mode_e       mode;
        logic              asid_en;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  tag;
    } flush_req_t;
endpackage

// File: rtl/iotlb_flush_decode.sv
// Splits the 32-bit invalidation command into mode, tag qualifier and region tag.
// Assumes: mode in [1:0], tag enable in [31], tag in [30:24], region in [19:0].
module iotlb_flush_decode
    import iotlb_pkg::*;
(
    input  logic        flush_valid,
    input  logic [31:0] flush_cmd,
    output flush_req_t  req
);
    logic unused_cmd;
    assign unused_cmd = ^flush_cmd[23:20];

    // decode command fields; mode 1 is reserved and never acts
    always_comb begin
        req.mode    = flush_mode_e'(flush_cmd[1:0]);
        req.act     = flush_valid && (flush_cmd[1:0] != FL_NONE);
        req.asid_en = flush_cmd[31];
        req.asid    = flush_cmd[30:24];
        req.tag     = flush_cmd[VPN_W-1:0];
    end
endmodule

// File: rtl/iotlb_line.sv
// Compare logic for one cache line: lookup match, fill match and flush kill.
// Assumes the caller applies kill before fill, so both matches see post-flush state.
module iotlb_line
    import iotlb_pkg::*;
(
    input  tlb_line_t          line,
    input  logic               active,
    input  flush_req_t         fl,
    input  logic [ASID_W-1:0]  lk_asid,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0]  fill_asid,
    input  logic [VPN_W-1:0]   fill_vpn,
    output logic               kill,
    output logic               lk_match,
    output logic               fill_match
);
    logic asid_ok, region_ok;
    logic unused_tag;
    assign unused_tag = ^fl.tag[GRP_LSB-1:0];

    // does the pending invalidation cover this line
    always_comb begin
        asid_ok = !fl.asid_en || (line.asid == fl.asid);
        unique case (fl.mode)
            FL_ALL:  region_ok = 1'b1;
            FL_SECT: region_ok = line.vpn[VPN_W-1:SECT_LSB] == fl.tag[VPN_W-1:SECT_LSB];
            FL_GRP:  region_ok = line.vpn[VPN_W-1:GRP_LSB]  == fl.tag[VPN_W-1:GRP_LSB];
            default: region_ok = 1'b0;
        endcase
        kill = line.vld && fl.act && asid_ok && region_ok;
    end

    // key comparisons against the surviving line
    always_comb begin
        lk_match   = line.vld && !kill && active &&
                     (line.asid == lk_asid) && (line.vpn == lk_vpn);
        fill_match = line.vld && !kill &&
                     (line.asid == fill_asid) && (line.vpn == fill_vpn);
    end
endmodule

// File: rtl/iotlb_victim.sv
// Chooses the line for a new translation: rotating pointer or lowest free active line.
// Assumes active_n <= ENTRIES; a pointer outside the active region counts as 0.
module iotlb_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rr_en,
    input  logic [CNT_W-1:0]   active_n,
    input  logic [ENTRIES-1:0] free_vec,
    input  logic               alloc,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] ptr_q, rr_pick, free_pick, ptr_nxt;
    logic             free_found;

    // rotating pick and its successor
    always_comb begin
        rr_pick = (CNT_W'(ptr_q) < active_n) ? ptr_q : '0;
        ptr_nxt = (CNT_W'(rr_pick) + CNT_W'(1) >= active_n) ? '0 : rr_pick + IDX_W'(1);
    end

    // lowest free line inside the active region
    always_comb begin
        free_pick  = '0;
        free_found = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_vec[i] && (CNT_W'(i) < active_n)) begin
                free_pick  = IDX_W'(i);
                free_found = 1'b1;
            end
        end
        victim = rr_en ? rr_pick : (free_found ? free_pick : '0);
    end

    // pointer moves only on a new allocation in rotating mode
    always_ff @(posedge clk) begin
        if (!rst_n)              ptr_q <= '0;
        else if (alloc && rr_en) ptr_q <= ptr_nxt;
    end
endmodule

// File: rtl/iotlb_asid.sv
// Fully associative, tag-qualified translation cache with encoded invalidation.
// Lookup is combinational; invalidation, then fill, update the lines at the clock edge.
// Assumes one fill and one invalidation command at most per cycle.
module iotlb_asid
    import iotlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_active_lines,
    input  logic              cfg_rr_en,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PERM_W-1:0] lk_perm,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              flush_valid,
    input  logic [31:0]       flush_cmd
);
    tlb_line_t          lines_q [ENTRIES];
    flush_req_t         fl;
    logic [ENTRIES-1:0] active_vec, kill_vec, hit_vec, fmatch_vec, free_vec, vld_vec;
    logic               fill_hit_any, alloc;
    logic [IDX_W-1:0]   fill_idx, victim;

    iotlb_flush_decode u_dec (
        .flush_valid (flush_valid),
        .flush_cmd   (flush_cmd),
        .req         (fl)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_line
        assign active_vec[g] = CNT_W'(g) < cfg_active_lines;
        assign vld_vec[g]    = lines_q[g].vld;
        assign free_vec[g]   = !lines_q[g].vld || kill_vec[g];
        iotlb_line u_line (
            .line       (lines_q[g]),
            .active     (active_vec[g]),
            .fl         (fl),
            .lk_asid    (lk_asid),
            .lk_vpn     (lk_vpn),
            .fill_asid  (fill_asid),
            .fill_vpn   (fill_vpn),
            .kill       (kill_vec[g]),
            .lk_match   (hit_vec[g]),
            .fill_match (fmatch_vec[g])
        );
    end

    // merge the (at most one) matching line onto the lookup outputs
    always_comb begin
        lk_hit  = |hit_vec;
        lk_pfn  = '0;
        lk_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                lk_pfn  = lk_pfn  | lines_q[i].pfn;
                lk_perm = lk_perm | lines_q[i].perm;
            end
        end
    end

    // locate an in-place refill target among active lines
    always_comb begin
        fill_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (fmatch_vec[i] && active_vec[i]) fill_idx = IDX_W'(i);
        end
        fill_hit_any = |(fmatch_vec & active_vec);
        alloc        = fill_valid && !fill_hit_any && (cfg_active_lines != '0);
    end

    iotlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_vic (
        .clk      (clk),
        .rst_n    (rst_n),
        .rr_en    (cfg_rr_en),
        .active_n (cfg_active_lines),
        .free_vec (free_vec),
        .alloc    (alloc),
        .victim   (victim)
    );

    // line update: invalidate first, then drop stale copies, then write the fill
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                lines_q[i] <= '0;
            end else begin
                if (kill_vec[i]) lines_q[i].vld <= 1'b0;
                if (fill_valid && fmatch_vec[i] && !active_vec[i]) lines_q[i].vld <= 1'b0;
                if (fill_valid && ((fill_hit_any && fill_idx == IDX_W'(i)) ||
                                   (alloc && victim == IDX_W'(i)))) begin
                    lines_q[i] <= '{vld: 1'b1, asid: fill_asid, vpn: fill_vpn,
                                    pfn: fill_pfn, perm: fill_perm};
                end
            end
        end
    end
endmodule

// File: rtl/iotlb_asid_checker.sv
// Temporal checks on the translation cache, bound into every instance.
// Assumes the default 8-line configuration widths from the package.
module iotlb_asid_checker
    import iotlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CNT_W-1:0]   cfg_active_lines,
    input logic [ASID_W-1:0]  lk_asid,
    input logic [VPN_W-1:0]   lk_vpn,
    input logic               lk_hit,
    input logic [PFN_W-1:0]   lk_pfn,
    input logic [PERM_W-1:0]  lk_perm,
    input logic               fill_valid,
    input logic [ASID_W-1:0]  fill_asid,
    input logic [VPN_W-1:0]   fill_vpn,
    input logic [PFN_W-1:0]   fill_pfn,
    input logic               flush_valid,
    input logic [31:0]        flush_cmd,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ENTRIES-1:0] vld_vec
);
    // R3: an unqualified flush-all is visible to a lookup in the same cycle
    a_r3_flush_all_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && flush_cmd[1:0] == 2'b00 && !flush_cmd[31]) |-> !lk_hit);

    // R8: no active lines means no hits
    a_r8_no_lines_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_active_lines == '0) |-> !lk_hit);

    // R11: a key is never held by two lines that both answer a lookup
    a_r11_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R6: the reserved mode leaves the stored lines untouched
    a_r6_reserved_mode_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && flush_cmd[1:0] == 2'b01 && !fill_valid) |=> $stable(vld_vec));

    // R2: zeroed outputs on a miss
    a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pfn == '0 && lk_perm == '0));

    // R2: a translation just filled answers the next lookup of its key
    a_r2_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && cfg_active_lines != '0) |=>
        (!(!flush_valid && $stable(cfg_active_lines) &&
           lk_asid == $past(fill_asid) && lk_vpn == $past(fill_vpn)) ||
         (lk_hit && lk_pfn == $past(fill_pfn))));
endmodule

bind iotlb_asid iotlb_asid_checker #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_active_lines (cfg_active_lines),
    .lk_asid          (lk_asid),
    .lk_vpn           (lk_vpn),
    .lk_hit           (lk_hit),
    .lk_pfn           (lk_pfn),
    .lk_perm          (lk_perm),
    .fill_valid       (fill_valid),
    .fill_asid        (fill_asid),
    .fill_vpn         (fill_vpn),
    .fill_pfn         (fill_pfn),
    .flush_valid      (flush_valid),
    .flush_cmd        (flush_cmd),
    .hit_vec          (hit_vec),
    .vld_vec          (vld_vec)
);

// File: tb/iotlb_asid_test.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// compared against a behavioural line model kept in the bench.
module iotlb_asid_test;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_active_lines = 4'd8;
    logic        cfg_rr_en = 1'b1;
    logic [6:0]  lk_asid = '0;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit;
    logic [19:0] lk_pfn;
    logic [2:0]  lk_perm;
    logic        fill_valid = 1'b0;
    logic [6:0]  fill_asid = '0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic [2:0]  fill_perm = '0;
    logic        flush_valid = 1'b0;
    logic [31:0] flush_cmd = '0;

    int checks = 0;
    int errors = 0;

    // behavioural model
    bit          m_vld  [N];
    bit [6:0]    m_asid [N];
    bit [19:0]   m_vpn  [N];
    bit [19:0]   m_pfn  [N];
    bit [2:0]    m_perm [N];
    int          m_ptr;

    always #2 clk = ~clk;

    iotlb_asid uut (
        .clk(clk), .rst_n(rst_n), .cfg_active_lines(cfg_active_lines), .cfg_rr_en(cfg_rr_en),
        .lk_asid(lk_asid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
        .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm),
        .flush_valid(flush_valid), .flush_cmd(flush_cmd)
    );

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // line i is removed by the command on the inputs (R3, R4, R5, R6)
    function automatic bit m_kill(int i);
        bit a_ok, r_ok;
        if (!flush_valid || !m_vld[i] || flush_cmd[1:0] == 2'b01) return 1'b0;
        a_ok = !flush_cmd[31] || (m_asid[i] == flush_cmd[30:24]);
        case (flush_cmd[1:0])
            2'b00:   r_ok = 1'b1;
            2'b10:   r_ok = m_vpn[i][19:10] == flush_cmd[19:10];
            default: r_ok = m_vpn[i][19:2] == flush_cmd[19:2];
        endcase
        return a_ok && r_ok;
    endfunction

    // compare lookup outputs with the model, then advance one clock
    task automatic step(string req);
        bit          e_hit = 1'b0;
        bit [19:0]   e_pfn = '0;
        bit [2:0]    e_perm = '0;
        bit          kill [N];
        int          act, hit_at, vic;
        bit          found;
        #1;
        act = int'(cfg_active_lines);
        for (int i = 0; i < N; i++) kill[i] = m_kill(i);
        for (int i = 0; i < act; i++) begin
            if (m_vld[i] && !kill[i] && m_asid[i] == lk_asid && m_vpn[i] == lk_vpn) begin
                e_hit = 1'b1; e_pfn = m_pfn[i]; e_perm = m_perm[i];
            end
        end
        checks++;
        if (lk_hit !== e_hit || lk_pfn !== e_pfn || lk_perm !== e_perm) begin
            errors++;
            $display("FAIL %s: hit/pfn/perm actual %b/%h/%b expected %b/%h/%b",
                     req, lk_hit, lk_pfn, lk_perm, e_hit, e_pfn, e_perm);
        end
        @(posedge clk);
        for (int i = 0; i < N; i++) if (kill[i]) m_vld[i] = 1'b0;
        if (fill_valid) begin
            hit_at = -1;
            for (int i = 0; i < N; i++) begin
                if (m_vld[i] && m_asid[i] == fill_asid && m_vpn[i] == fill_vpn) begin
                    if (i < act) hit_at = i; else m_vld[i] = 1'b0;
                end
            end
            vic = -1;
            if (hit_at >= 0) vic = hit_at;
            else if (act > 0) begin
                if (cfg_rr_en) begin
                    vic = (m_ptr < act) ? m_ptr : 0;
                    m_ptr = (vic + 1 >= act) ? 0 : vic + 1;
                end else begin
                    found = 1'b0; vic = 0;
                    for (int i = 0; i < act; i++)
                        if (!found && !m_vld[i]) begin vic = i; found = 1'b1; end
                end
            end
            if (vic >= 0) begin
                m_vld[vic] = 1'b1; m_asid[vic] = fill_asid; m_vpn[vic] = fill_vpn;
                m_pfn[vic] = fill_pfn; m_perm[vic] = fill_perm;
            end
        end
        @(negedge clk);
        fill_valid = 1'b0;
        flush_valid = 1'b0;
    endtask

    task automatic look(input bit [6:0] a, input bit [19:0] v);
        lk_asid = a; lk_vpn = v;
    endtask

    task automatic fill(input bit [6:0] a, input bit [19:0] v, input bit [19:0] p, input bit [2:0] pm);
        fill_valid = 1'b1; fill_asid = a; fill_vpn = v; fill_pfn = p; fill_perm = pm;
    endtask

    task automatic flush(input bit [31:0] c);
        flush_valid = 1'b1; flush_cmd = c;
    endtask

    initial begin
        int r;
        r = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        m_ptr = 0;

        // R1: nothing stored after reset
        look(7'd1, 20'h00010); step("R1");
        look(7'd0, 20'h00000); step("R1");

        // R2: fill three keys, look each up
        fill(7'd1, 20'h00010, 20'hAAAA1, 3'b101); step("R2");
        fill(7'd2, 20'h00011, 20'hAAAA2, 3'b011); step("R2");
        fill(7'd1, 20'h00415, 20'hAAAA3, 3'b111); step("R2");
        look(7'd1, 20'h00010); step("R2");
        look(7'd2, 20'h00011); step("R2");
        look(7'd2, 20'h00010); step("R2");      // other tag misses
        // R11: refill in place, pointer unchanged
        fill(7'd1, 20'h00010, 20'hBBBB1, 3'b001); step("R11");
        look(7'd1, 20'h00010); step("R11");
        // R6: reserved mode keeps lines
        flush(32'h0000_0001); step("R6");
        look(7'd2, 20'h00011); step("R6");
        // R5: group flush qualified by tag 2 covers 0x00010..0x00013 of tag 2 only
        flush({1'b1, 7'd2, 4'h0, 20'h00010} | 32'h3); step("R5");
        look(7'd2, 20'h00011); step("R5");
        look(7'd1, 20'h00010); step("R5");
        // R4: section flush without tag removes VA[31:22]=1 (vpn 0x004xx)
        look(7'd1, 20'h00415); flush(32'h0000_0402); step("R4");
        look(7'd1, 20'h00415); step("R4");
        look(7'd1, 20'h00010); step("R4");
        // R3: flush-all for tag 1, then R7 same-cycle flush and fill
        fill(7'd3, 20'h00020, 20'hCCCC3, 3'b110); step("R2");
        look(7'd1, 20'h00010); flush({1'b1, 7'd1, 24'h0}); step("R3");
        look(7'd3, 20'h00020); step("R3");
        look(7'd3, 20'h00020); flush(32'h0); fill(7'd3, 20'h00020, 20'hDDDD3, 3'b010); step("R7");
        look(7'd3, 20'h00020); step("R7");
        flush(32'h0); step("R3");
        look(7'd3, 20'h00020); step("R3");

        // R9/R8: two active lines, third fill evicts line 0 in rotation
        cfg_active_lines = 4'd2;
        fill(7'd4, 20'h00100, 20'h11111, 3'b100); step("R9");
        fill(7'd4, 20'h00101, 20'h22222, 3'b100); step("R9");
        fill(7'd4, 20'h00102, 20'h33333, 3'b100); step("R9");
        look(7'd4, 20'h00100); step("R9");
        look(7'd4, 20'h00101); step("R9");
        look(7'd4, 20'h00102); step("R9");
        cfg_active_lines = 4'd0;
        look(7'd4, 20'h00101); step("R8");
        fill(7'd5, 20'h00200, 20'h44444, 3'b001); step("R8");
        cfg_active_lines = 4'd1;
        look(7'd4, 20'h00101); step("R8");       // line 1 now outside region
        // R11: key held in line 1 outside region; refill goes to line 0, stale copy dropped
        fill(7'd4, 20'h00101, 20'h55555, 3'b011); step("R11");
        cfg_active_lines = 4'd8;
        look(7'd4, 20'h00101); step("R11");
        // R10: first free line, pointer held
        flush(32'h0); step("R10");
        cfg_rr_en = 1'b0;
        fill(7'd6, 20'h00300, 20'h66660, 3'b001); step("R10");
        fill(7'd6, 20'h00301, 20'h66661, 3'b001); step("R10");
        flush({1'b1, 7'd6, 4'h0, 20'h00300} | 32'h3); step("R10");
        fill(7'd6, 20'h00305, 20'h66665, 3'b001); step("R10");
        look(7'd6, 20'h00305); step("R10");

        // random phase (R2, R3, R4, R5, R7, R8, R9, R10, R11)
        cfg_rr_en = 1'b1;
        for (int n = 0; n < 4000; n++) begin
            bit [19:0] v;
            v = {9'h0, 1'($urandom % 2), 6'h0, 4'($urandom % 16)};
            look(7'($urandom % 4), v);
            if ($urandom % 3 == 0) begin
                v = {9'h0, 1'($urandom % 2), 6'h0, 4'($urandom % 16)};
                fill(7'($urandom % 4), v, 20'($urandom), 3'($urandom));
            end
            if ($urandom % 8 == 0) begin
                v = {9'h0, 1'($urandom % 2), 6'h0, 4'($urandom % 16)};
                flush({1'($urandom), 7'($urandom % 4), 4'h0, v[19:2], 2'($urandom)});
            end
            if ($urandom % 200 == 0) cfg_active_lines = 4'($urandom % 9);
            if ($urandom % 150 == 0) cfg_rr_en = 1'($urandom);
            step("R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule